// File: doc/BRIEF.md
# Dual MAC Accumulator Writeback Unit

This block holds two multiply-accumulate lanes, each with a 40-bit signed accumulator. On every valid operation, each enabled lane multiplies two signed 16-bit operand halves and adds the product to its accumulator. In fractional mode the product is doubled first. The single product that cannot be doubled, -1 times -1, is clamped to the largest positive 32-bit value.

The same operation may also send lane results to a small register file, in one of three ways:
- **Packed form:** both lanes go into one 32-bit register as two 16-bit halves.
- **Pair form:** both lanes go, saturated to 32 bits, into an aligned even/odd register pair.
- **Lone form:** a single lane writes either a 16-bit half or a full 32-bit register.

Routing is fixed by lane. Lane 1 always feeds the high half or the odd register, and lane 0 feeds the low half or the even register.

The accumulator update and the register write happen on the same clock edge. The write ports therefore carry the post-accumulate value, combinationally, during the cycle the operation is presented. A pair request whose destination index is odd is rejected: the error output rises, and neither the register file nor the accumulators change.

Top module: `dmac_wb`

## Requirements
- R1: A synchronous active-high reset clears both accumulators to zero, so a writeback with no accumulation directly after reset carries zero.
- R2: In integer mode (`op_frac`=0) an enabled lane adds the signed 16x16 product of its operands to its 40-bit accumulator, wrapping modulo 2^40.
- R3: In fractional mode (`op_frac`=1) the product is shifted left by one before it is added, and the operand pair 0x8000 x 0x8000 contributes exactly 0x7FFF_FFFF.
- R4: A 16-bit writeback in fractional mode adds 0x8000 to the accumulator, takes bits 39..16 of the sum as a signed value, and saturates it to 0x8000..0x7FFF.
- R5: A 16-bit writeback in integer mode saturates the whole accumulator to the signed 16-bit range.
- R6: A 32-bit writeback (`op_wide`=1) saturates the whole accumulator to 0x8000_0000..0x7FFF_FFFF.
- R7: Packed form (`op_wide`=0, `op_wb_en`=2'b11) places lane 1 in half mask 2'b10 (bits 31..16) and lane 0 in half mask 2'b01 (bits 15..0), both at index `op_dst`. The unused half of each data word is zero.
- R8: Pair form (`op_wide`=1, `op_wb_en`=2'b11, `op_dst` even) writes lane 0 to index `op_dst` and lane 1 to index `op_dst`+1, both with half mask 2'b11.
- R9: A pair request with odd `op_dst` raises `op_err` in that cycle, asserts no write enable, and leaves both accumulators unchanged.
- R10: A lone writeback asserts only the named lane's write enable, at index `op_dst` with no alignment rule. The other lane may still accumulate without writing.
- R11: The written value is the accumulator after this cycle's addition.
- R12: While `op_valid` is low, no write enable is asserted and both accumulators hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_frac | input | 1 | 1 = fractional type, 0 = integer type |
| op_acc_en | input | 2 | Per-lane accumulate enable (bit 1 = lane 1) |
| op_wb_en | input | 2 | Per-lane writeback enable (bit 1 = lane 1) |
| op_wide | input | 1 | 1 = 32-bit writeback, 0 = 16-bit half writeback |
| op_dst | input | IDX_W | Destination register index |
| src_a0 | input | 16 | Lane 0 first operand half |
| src_b0 | input | 16 | Lane 0 second operand half |
| src_a1 | input | 16 | Lane 1 first operand half |
| src_b1 | input | 16 | Lane 1 second operand half |
| wr_en | output | 2 | Per-lane register write enable (bit 1 = lane 1 port) |
| wr_idx0 | output | IDX_W | Lane 0 port register index |
| wr_idx1 | output | IDX_W | Lane 1 port register index |
| wr_half0 | output | 2 | Lane 0 port half mask (bit 1 = bits 31..16) |
| wr_half1 | output | 2 | Lane 1 port half mask (bit 1 = bits 31..16) |
| wr_data0 | output | 32 | Lane 0 port write data |
| wr_data1 | output | 32 | Lane 1 port write data |
| op_err | output | 1 | Misaligned pair request rejected |

## Verification
The bench builds the block with its defaults: a 40-bit accumulator and eight registers (3-bit index).

The eight guard bits let the accumulator run well past both the 16-bit and the 32-bit limits in a few operations. Repeated -1 x -1 fractional products and repeated 0x8000 x 0x7FFF integer products therefore reach both saturation edges of every extraction.

With eight registers, the pair form can be driven at the top pair (6, 7), and an odd index reaches the rejection path. Rounding is probed just above and just below the half-way point, and at the negative edge where rounding lands exactly on zero.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int HALF_W = 16;
    localparam int REG_W  = 2 * HALF_W;

    typedef enum logic {
        WB_HALF = 1'b0,
        WB_FULL = 1'b1
    } wb_width_e;

    localparam logic [1:0] MASK_LO   = 2'b01;
    localparam logic [1:0] MASK_HI   = 2'b10;
    localparam logic [1:0] MASK_BOTH = 2'b11;

    typedef struct packed {
        logic [1:0]       half;
        logic [REG_W-1:0] data;
    } wr_slot_t;

    typedef struct packed {
        logic [HALF_W-1:0] h16;
        logic [REG_W-1:0]  w32;
    } lane_res_t;

endpackage

// File: rtl/dmac_lane.sv
module dmac_lane
    import dmac_pkg::*;
#(
    parameter int ACC_W = 40
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     acc_go,
    input  logic                     frac,
    input  logic [HALF_W-1:0]        opa,
    input  logic [HALF_W-1:0]        opb,
    output logic signed [ACC_W-1:0]  acc_q,
    output logic signed [ACC_W-1:0]  acc_nx
);
    localparam int PW = 2 * HALF_W;
    localparam logic [HALF_W-1:0] NEG_ONE = {1'b1, {(HALF_W-1){1'b0}}};
    localparam logic signed [PW-1:0] POS_MAX = {1'b0, {(PW-1){1'b1}}};

    logic signed [PW-1:0] ext_a, ext_b, raw, scaled;
    logic                 corner;

    always_comb begin
        ext_a  = PW'(signed'(opa));
        ext_b  = PW'(signed'(opb));
        raw    = ext_a * ext_b;
        corner = frac && (opa == NEG_ONE) && (opb == NEG_ONE);
        if (corner)
            scaled = POS_MAX;
        else if (frac)
            scaled = raw <<< 1;
        else
            scaled = raw;
        acc_nx = acc_go ? (acc_q + ACC_W'(scaled)) : acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else
            acc_q <= acc_nx;
    end
endmodule

// File: rtl/dmac_extract.sv
module dmac_extract
    import dmac_pkg::*;
#(
    parameter int ACC_W = 40
) (
    input  logic signed [ACC_W-1:0] acc,
    input  logic                    frac,
    output lane_res_t               res
);
    localparam int XW = ACC_W + 1;
    localparam logic signed [XW-1:0] ONE   = XW'(1);
    localparam logic signed [XW-1:0] RND   = ONE <<< (HALF_W - 1);
    localparam logic signed [XW-1:0] H_MAX = (ONE <<< (HALF_W - 1)) - ONE;
    localparam logic signed [XW-1:0] H_MIN = -H_MAX - ONE;
    localparam logic signed [XW-1:0] W_MAX = (ONE <<< (REG_W - 1)) - ONE;
    localparam logic signed [XW-1:0] W_MIN = -W_MAX - ONE;

    logic signed [XW-1:0] wide_acc, rsum, rhi, sel;

    always_comb begin
        wide_acc = XW'(acc);
        rsum     = wide_acc + RND;
        rhi      = rsum >>> HALF_W;
        sel      = frac ? rhi : wide_acc;

        if (sel > H_MAX)
            res.h16 = H_MAX[HALF_W-1:0];
        else if (sel < H_MIN)
            res.h16 = H_MIN[HALF_W-1:0];
        else
            res.h16 = sel[HALF_W-1:0];

        if (wide_acc > W_MAX)
            res.w32 = W_MAX[REG_W-1:0];
        else if (wide_acc < W_MIN)
            res.w32 = W_MIN[REG_W-1:0];
        else
            res.w32 = wide_acc[REG_W-1:0];
    end
endmodule

// File: rtl/dmac_route.sv
module dmac_route
    import dmac_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             valid,
    input  wb_width_e        width,
    input  logic [1:0]       wb_en,
    input  logic [IDX_W-1:0] dst,
    input  lane_res_t        res0,
    input  lane_res_t        res1,
    output logic             err,
    output logic [1:0]       en,
    output logic [IDX_W-1:0] idx0,
    output logic [IDX_W-1:0] idx1,
    output wr_slot_t         slot0,
    output wr_slot_t         slot1
);
    logic pair, full;

    always_comb begin
        full = (width == WB_FULL);
        pair = full && (wb_en == 2'b11);
        err  = valid && pair && dst[0];
        en   = (valid && !err) ? wb_en : 2'b00;

        idx0 = dst;
        idx1 = pair ? {dst[IDX_W-1:1], 1'b1} : dst;

        if (full) begin
            slot0.half = MASK_BOTH;
            slot0.data = res0.w32;
            slot1.half = MASK_BOTH;
            slot1.data = res1.w32;
        end else begin
            slot0.half = MASK_LO;
            slot0.data = {{HALF_W{1'b0}}, res0.h16};
            slot1.half = MASK_HI;
            slot1.data = {res1.h16, {HALF_W{1'b0}}};
        end
    end
endmodule

// File: rtl/dmac_wb.sv
module dmac_wb
    import dmac_pkg::*;
#(
    parameter int ACC_W = 40,
    parameter int NREG  = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic             op_frac,
    input  logic [1:0]       op_acc_en,
    input  logic [1:0]       op_wb_en,
    input  logic             op_wide,
    input  logic [IDX_W-1:0] op_dst,
    input  logic [15:0]      src_a0,
    input  logic [15:0]      src_b0,
    input  logic [15:0]      src_a1,
    input  logic [15:0]      src_b1,
    output logic [1:0]       wr_en,
    output logic [IDX_W-1:0] wr_idx0,
    output logic [IDX_W-1:0] wr_idx1,
    output logic [1:0]       wr_half0,
    output logic [1:0]       wr_half1,
    output logic [31:0]      wr_data0,
    output logic [31:0]      wr_data1,
    output logic             op_err
);
    localparam int LANES = 2;

    logic [HALF_W-1:0]       opa [LANES];
    logic [HALF_W-1:0]       opb [LANES];
    logic signed [ACC_W-1:0] acc_cur [LANES];
    logic signed [ACC_W-1:0] acc_nxt [LANES];
    lane_res_t               res [LANES];
    logic [LANES-1:0]        go;
    wr_slot_t                slot0, slot1;
    wb_width_e               width;

    assign opa[0] = src_a0;
    assign opb[0] = src_b0;
    assign opa[1] = src_a1;
    assign opb[1] = src_b1;
    assign width  = wb_width_e'(op_wide);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign go[g] = op_valid && op_acc_en[g] && !op_err;

        dmac_lane #(.ACC_W(ACC_W)) lane_i (
            .clk    (clk),
            .rst    (rst),
            .acc_go (go[g]),
            .frac   (op_frac),
            .opa    (opa[g]),
            .opb    (opb[g]),
            .acc_q  (acc_cur[g]),
            .acc_nx (acc_nxt[g])
        );

        dmac_extract #(.ACC_W(ACC_W)) ext_i (
            .acc  (acc_nxt[g]),
            .frac (op_frac),
            .res  (res[g])
        );
    end

    dmac_route #(.IDX_W(IDX_W)) route_i (
        .valid (op_valid),
        .width (width),
        .wb_en (op_wb_en),
        .dst   (op_dst),
        .res0  (res[0]),
        .res1  (res[1]),
        .err   (op_err),
        .en    (wr_en),
        .idx0  (wr_idx0),
        .idx1  (wr_idx1),
        .slot0 (slot0),
        .slot1 (slot1)
    );

    assign wr_half0 = slot0.half;
    assign wr_data0 = slot0.data;
    assign wr_half1 = slot1.half;
    assign wr_data1 = slot1.data;
endmodule

// File: rtl/dmac_wb_chk.sv
module dmac_wb_chk #(
    parameter int ACC_W = 40,
    parameter int IDX_W = 3
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    op_valid,
    input logic                    op_err,
    input logic [1:0]              wr_en,
    input logic [IDX_W-1:0]        wr_idx0,
    input logic [IDX_W-1:0]        wr_idx1,
    input logic [1:0]              wr_half0,
    input logic [1:0]              wr_half1,
    input logic signed [ACC_W-1:0] acc0,
    input logic signed [ACC_W-1:0] acc1
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (acc0 == '0 && acc1 == '0));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> (wr_en == 2'b00));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (acc0 == $past(acc0) && acc1 == $past(acc1)));

    p_reject_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        op_err |-> (wr_en == 2'b00));

    p_reject_hold_r9: assert property (@(posedge clk) disable iff (rst)
        op_err |=> (acc0 == $past(acc0) && acc1 == $past(acc1)));

    p_pair_aligned_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en == 2'b11 && wr_half0 == 2'b11)
        |-> (wr_idx0[0] == 1'b0 && wr_idx1 == (wr_idx0 | IDX_W'(1)) && wr_half1 == 2'b11));

    p_pack_same_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en == 2'b11 && wr_half0 != 2'b11)
        |-> (wr_idx0 == wr_idx1 && wr_half0 == 2'b01 && wr_half1 == 2'b10));
endmodule

bind dmac_wb dmac_wb_chk #(.ACC_W(ACC_W), .IDX_W(IDX_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_err   (op_err),
    .wr_en    (wr_en),
    .wr_idx0  (wr_idx0),
    .wr_idx1  (wr_idx1),
    .wr_half0 (wr_half0),
    .wr_half1 (wr_half1),
    .acc0     (acc_cur[0]),
    .acc1     (acc_cur[1])
);

// File: tb/dmac_wb_tb_top.sv
module dmac_wb_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0, op_frac = 1'b0, op_wide = 1'b0;
    logic [1:0]  op_acc_en = 2'b00, op_wb_en = 2'b00;
    logic [2:0]  op_dst = 3'd0;
    logic [15:0] src_a0 = '0, src_b0 = '0, src_a1 = '0, src_b1 = '0;
    logic [1:0]  wr_en, wr_half0, wr_half1;
    logic [2:0]  wr_idx0, wr_idx1;
    logic [31:0] wr_data0, wr_data1;
    logic        op_err;

    always #10 clk = ~clk;

    dmac_wb dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_frac(op_frac),
        .op_acc_en(op_acc_en), .op_wb_en(op_wb_en), .op_wide(op_wide),
        .op_dst(op_dst), .src_a0(src_a0), .src_b0(src_b0),
        .src_a1(src_a1), .src_b1(src_b1), .wr_en(wr_en),
        .wr_idx0(wr_idx0), .wr_idx1(wr_idx1), .wr_half0(wr_half0),
        .wr_half1(wr_half1), .wr_data0(wr_data0), .wr_data1(wr_data1),
        .op_err(op_err)
    );

    typedef struct {
        string       tag;
        logic        err;
        logic [1:0]  en;
        logic [2:0]  i0, i1;
        logic [1:0]  h0, h1;
        logic [31:0] d0, d1;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;
    logic signed [39:0] m_acc [2];

    function automatic logic signed [39:0] m_prod(bit frac, logic [15:0] a, logic [15:0] b);
        longint p;
        p = longint'($signed(a)) * longint'($signed(b));
        if (frac) begin
            if (a == 16'h8000 && b == 16'h8000) p = 64'sh7FFF_FFFF;
            else p = p * 2;
        end
        return 40'(p);
    endfunction

    function automatic logic [15:0] m_h16(bit frac, logic signed [39:0] acc);
        longint v;
        v = longint'(acc);
        if (frac) v = (v + 32768) >>> 16;
        if (v > 32767) v = 32767;
        else if (v < -32768) v = -32768;
        return v[15:0];
    endfunction

    function automatic logic [31:0] m_w32(logic signed [39:0] acc);
        longint v;
        v = longint'(acc);
        if (v > 64'sd2147483647) v = 64'sd2147483647;
        else if (v < -64'sd2147483648) v = -64'sd2147483648;
        return v[31:0];
    endfunction

    task automatic op(string tag, bit valid, bit frac, logic [1:0] acc_en,
                      logic [1:0] wb_en, bit wide, logic [2:0] dst,
                      logic [15:0] a0, logic [15:0] b0,
                      logic [15:0] a1, logic [15:0] b1);
        exp_t e;
        logic signed [39:0] nx [2];
        bit go, pair;
        @(negedge clk);
        op_valid = valid; op_frac = frac; op_acc_en = acc_en; op_wb_en = wb_en;
        op_wide = wide; op_dst = dst;
        src_a0 = a0; src_b0 = b0; src_a1 = a1; src_b1 = b1;
        pair  = wide && (wb_en == 2'b11);
        e.tag = tag;
        e.err = valid && pair && dst[0];
        go    = valid && !e.err;
        nx[0] = (go && acc_en[0]) ? m_acc[0] + m_prod(frac, a0, b0) : m_acc[0];
        nx[1] = (go && acc_en[1]) ? m_acc[1] + m_prod(frac, a1, b1) : m_acc[1];
        e.en  = go ? wb_en : 2'b00;
        e.i0  = dst;
        e.i1  = pair ? dst + 3'd1 : dst;
        e.h0  = wide ? 2'b11 : 2'b01;
        e.h1  = wide ? 2'b11 : 2'b10;
        e.d0  = wide ? m_w32(nx[0]) : {16'h0, m_h16(frac, nx[0])};
        e.d1  = wide ? m_w32(nx[1]) : {m_h16(frac, nx[1]), 16'h0};
        q.push_back(e);
        m_acc[0] = nx[0];
        m_acc[1] = nx[1];
    endtask

    task automatic idle(string tag);
        op(tag, 1'b0, 1'b0, 2'b11, 2'b11, 1'b1, 3'd0, 16'h1234, 16'h0F0F, 16'h7FFF, 16'h8000);
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst = 1'b1;
        op_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_acc[0] = '0;
        m_acc[1] = '0;
    endtask

    // Monitor: compares the combinational write ports mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                bit ok;
                e  = q.pop_front();
                ok = (op_err === e.err) && (wr_en === e.en);
                if (e.en[0]) ok = ok && (wr_idx0 === e.i0) && (wr_half0 === e.h0) && (wr_data0 === e.d0);
                if (e.en[1]) ok = ok && (wr_idx1 === e.i1) && (wr_half1 === e.h1) && (wr_data1 === e.d1);
                checks++;
                if (!ok) begin
                    errors++;
                    $display("FAIL %s: got err=%b en=%b i0=%0d h0=%b d0=%h i1=%0d h1=%b d1=%h exp err=%b en=%b i0=%0d h0=%b d0=%h i1=%0d h1=%b d1=%h",
                             e.tag, op_err, wr_en, wr_idx0, wr_half0, wr_data0, wr_idx1, wr_half1, wr_data1,
                             e.err, e.en, e.i0, e.h0, e.d0, e.i1, e.h1, e.d1);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_acc[0] = '0;
        m_acc[1] = '0;
        reset_dut();
        idle("R1 idle after reset");
        op("R1 zero pair after reset", 1, 0, 2'b00, 2'b11, 1, 3'd2, 16'd5, 16'd5, 16'd5, 16'd5);
        op("R2 integer pair accumulate", 1, 0, 2'b11, 2'b11, 1, 3'd4, 16'd300, 16'hFFF9, 16'd1000, 16'd1000);
        op("R11 post-accumulate value", 1, 0, 2'b11, 2'b11, 1, 3'd4, 16'd300, 16'hFFF9, 16'd1000, 16'd1000);
        op("R5 integer 16-bit saturation packed", 1, 0, 2'b11, 2'b11, 0, 3'd6, 16'd1, 16'd5, 16'd1, 16'd1);
        op("R7 packed same index", 1, 0, 2'b11, 2'b11, 0, 3'd1, 16'd0, 16'd0, 16'd0, 16'd0);
        op("R8 pair top registers", 1, 0, 2'b00, 2'b11, 1, 3'd6, 16'd0, 16'd0, 16'd0, 16'd0);

        reset_dut();
        op("R3 fractional minus one squared", 1, 1, 2'b01, 2'b01, 1, 3'd5, 16'h8000, 16'h8000, 16'd0, 16'd0);
        op("R3 fractional doubled product", 1, 1, 2'b10, 2'b10, 0, 3'd0, 16'd0, 16'd0, 16'h4000, 16'h4000);
        op("R6 32-bit positive saturation", 1, 1, 2'b01, 2'b01, 1, 3'd0, 16'h8000, 16'h8000, 16'd0, 16'd0);
        op("R4 fractional 16-bit saturation", 1, 1, 2'b00, 2'b01, 0, 3'd0, 16'd0, 16'd0, 16'd0, 16'd0);

        reset_dut();
        op("R2 build 0x18000", 1, 0, 2'b01, 2'b00, 0, 3'd0, 16'd256, 16'd384, 16'd0, 16'd0);
        op("R4 round half up", 1, 1, 2'b00, 2'b01, 0, 3'd3, 16'd0, 16'd0, 16'd0, 16'd0);
        op("R2 build 0x17FFF", 1, 0, 2'b01, 2'b00, 0, 3'd0, 16'd1, 16'hFFFF, 16'd0, 16'd0);
        op("R4 round down", 1, 1, 2'b00, 2'b01, 0, 3'd3, 16'd0, 16'd0, 16'd0, 16'd0);
        op("R2 lane1 build -32768", 1, 0, 2'b10, 2'b00, 0, 3'd0, 16'd0, 16'd0, 16'h8000, 16'd1);
        op("R4 negative rounds to zero", 1, 1, 2'b00, 2'b10, 0, 3'd2, 16'd0, 16'd0, 16'd0, 16'd0);
        op("R5 integer minimum half", 1, 0, 2'b00, 2'b10, 0, 3'd2, 16'd0, 16'd0, 16'd0, 16'd0);

        reset_dut();
        for (int k = 0; k < 3; k++)
            op("R6 32-bit negative saturation", 1, 0, 2'b10, 2'b10, 1, 3'd1, 16'd0, 16'd0, 16'h8000, 16'h7FFF);
        op("R5 integer 16-bit negative saturation", 1, 0, 2'b00, 2'b10, 0, 3'd1, 16'd0, 16'd0, 16'd0, 16'd0);
        op("R9 misaligned pair rejected", 1, 0, 2'b11, 2'b11, 1, 3'd3, 16'd99, 16'd99, 16'd77, 16'd77);
        op("R9 accumulators unchanged", 1, 0, 2'b00, 2'b11, 1, 3'd2, 16'd0, 16'd0, 16'd0, 16'd0);
        op("R10 lane0 accumulates lane1 writes", 1, 0, 2'b01, 2'b10, 0, 3'd7, 16'd3, 16'd3, 16'd9, 16'd9);
        op("R10 lone wide lane1 odd index", 1, 0, 2'b00, 2'b10, 1, 3'd3, 16'd0, 16'd0, 16'd0, 16'd0);
        op("R10 lane0 readback", 1, 0, 2'b00, 2'b01, 1, 3'd6, 16'd0, 16'd0, 16'd0, 16'd0);
        op("R12 invalid op ignored", 0, 0, 2'b11, 2'b11, 1, 3'd0, 16'd7, 16'd7, 16'd7, 16'd7);
        op("R12 accumulators held", 1, 0, 2'b00, 2'b11, 1, 3'd0, 16'd0, 16'd0, 16'd0, 16'd0);
        idle("R12 idle quiet");

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule